// File: doc/BRIEF.md
# Floating-Point Multiply Special-Case Resolver

This block sits in front of a mantissa multiplier. It takes two operands in unpacked form, each described by a 3-bit class code, a sign and a payload field. It decides whether the product can be given directly, without any mantissa arithmetic, or whether the pair must go on to the multiplier.

When a direct result is possible, the block raises a bypass flag. It then gives the class and sign of the result, a selector naming the operand whose payload is forwarded, and the forwarded payload itself. It also reports two invalid-operation conditions: a signaling-NaN input, and an infinity multiplied by a zero.

NaN operands are resolved first. After that, the two operands are ranked so that the heavier class goes on the second side. The remaining cases are then tested in a fixed order: infinity first, then zero, and last the ordinary numbers. The decision is registered, so a request presented with `in_valid` produces its answer one clock later.

Top module: `fmul_special_resolver`

## Requirements
- R1: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signaling NaN. Codes 5 to 7 are handled as quiet NaNs. If either operand is a NaN, the block bypasses. The first operand (a) is forwarded when it is a NaN; otherwise the second (b) is forwarded. `out_pick` is 0 for a and 1 for b. The result class, sign and payload are those of the forwarded operand.
- R2: `flag_snan` is 1 exactly when at least one operand has class 4.
- R3: If neither operand is a NaN, one is infinity and the other is zero, the block bypasses with a default NaN. The default NaN has class 3, sign 0, `out_dflt` = 1 and payload `DFLT_PAY` (only the top payload bit set). `flag_imz` is 1, and `out_pick` is 0.
- R4: If neither operand is a NaN, at least one is infinity and neither is zero, the result has class 2 and its sign is the XOR of the two signs. It forwards the infinity operand, and if both are infinite it forwards b.
- R5: If neither operand is a NaN or infinity and at least one is zero, the result has class 0 and its sign is the XOR of the two signs. It forwards the zero operand, and if both are zero it forwards a.
- R6: If both operands have class 1, `out_bypass` is 0. The class is 1 and the sign is the XOR of the signs. `out_pick`, `out_dflt`, `out_pay` and both flags are 0.
- R7: `out_valid` equals `in_valid` of the previous cycle. In a cycle after `in_valid` was 0, every output is 0.
- R8: While reset is held and after its release until the first valid request, every output is 0.
- R9: `flag_imz` is raised only in the case of R3. `out_dflt` is raised only with `flag_imz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present on the operand inputs |
| a_cls | input | 3 | Class code of operand a |
| a_sign | input | 1 | Sign of operand a |
| a_pay | input | PAY_W | Payload of operand a |
| b_cls | input | 3 | Class code of operand b |
| b_sign | input | 1 | Sign of operand b |
| b_pay | input | PAY_W | Payload of operand b |
| out_valid | output | 1 | Decision present |
| out_bypass | output | 1 | Result is given directly |
| out_cls | output | 3 | Result class |
| out_sign | output | 1 | Result sign |
| out_pick | output | 1 | Forwarded operand: 0 = a, 1 = b |
| out_dflt | output | 1 | Result is the default NaN |
| out_pay | output | PAY_W | Forwarded or default payload |
| flag_snan | output | 1 | Signaling-NaN operand seen |
| flag_imz | output | 1 | Infinity times zero seen |

## Verification
All 64 pairs of class codes are applied, including the three unused codes, and each pair is tried with all four sign combinations. Each operand carries its own distinct payload. This lets the bench tell a forward of a from a forward of b, and a forwarded payload from the default payload.

Swapped pairs are among these cases: infinity with zero against zero with infinity, and number with zero against zero with number. They show that the ordering step, and not the input position, picks the returned operand. Cases with both operands infinite, both zero, or both NaN pin down which operand wins a tie. Idle cycles between requests check that the outputs clear.

// File: rtl/fmr_pkg.sv
package fmr_pkg;
    localparam logic [2:0] CLS_ZERO = 3'd0;
    localparam logic [2:0] CLS_NUM  = 3'd1;
    localparam logic [2:0] CLS_INF  = 3'd2;
    localparam logic [2:0] CLS_QNAN = 3'd3;
    localparam logic [2:0] CLS_SNAN = 3'd4;

    typedef logic [1:0] rank_t;
    localparam rank_t RANK_ZERO = 2'd0;
    localparam rank_t RANK_NUM  = 2'd1;
    localparam rank_t RANK_INF  = 2'd2;
    localparam rank_t RANK_NAN  = 2'd3;
endpackage

// File: rtl/fmr_rank.sv
module fmr_rank
    import fmr_pkg::*;
(
    input  logic [2:0] cls_i,
    output rank_t      rank_o,
    output logic       nan_o,
    output logic       snan_o
);
    always_comb begin
        snan_o = (cls_i == CLS_SNAN);
        unique case (cls_i)
            CLS_ZERO: rank_o = RANK_ZERO;
            CLS_NUM:  rank_o = RANK_NUM;
            CLS_INF:  rank_o = RANK_INF;
            default:  rank_o = RANK_NAN;
        endcase
        nan_o = (rank_o == RANK_NAN);
    end
endmodule

// File: rtl/fmr_sort.sv
module fmr_sort
    import fmr_pkg::*;
(
    input  rank_t rank_a_i,
    input  rank_t rank_b_i,
    output logic  heavy_idx_o,
    output rank_t heavy_rank_o,
    output rank_t light_rank_o
);
    logic swap;
    always_comb begin
        swap         = (rank_a_i > rank_b_i);
        heavy_idx_o  = ~swap;
        heavy_rank_o = swap ? rank_a_i : rank_b_i;
        light_rank_o = swap ? rank_b_i : rank_a_i;
    end
endmodule

// File: rtl/fmul_special_resolver.sv
module fmul_special_resolver
    import fmr_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       a_cls,
    input  logic             a_sign,
    input  logic [PAY_W-1:0] a_pay,
    input  logic [2:0]       b_cls,
    input  logic             b_sign,
    input  logic [PAY_W-1:0] b_pay,
    output logic             out_valid,
    output logic             out_bypass,
    output logic [2:0]       out_cls,
    output logic             out_sign,
    output logic             out_pick,
    output logic             out_dflt,
    output logic [PAY_W-1:0] out_pay,
    output logic             flag_snan,
    output logic             flag_imz
);
    localparam logic [PAY_W-1:0] DFLT_PAY = {1'b1, {(PAY_W-1){1'b0}}};
    localparam int NOPS = 2;

    typedef struct packed {
        logic             valid;
        logic             bypass;
        logic [2:0]       cls;
        logic             sign;
        logic             pick;
        logic             dflt;
        logic [PAY_W-1:0] pay;
        logic             snan;
        logic             imz;
    } res_t;

    res_t res_d, res_q;

    logic [2:0]       op_cls  [NOPS];
    logic             op_sign [NOPS];
    logic [PAY_W-1:0] op_pay  [NOPS];
    rank_t            op_rank [NOPS];
    logic             op_nan  [NOPS];
    logic             op_snan [NOPS];

    assign op_cls[0]  = a_cls;
    assign op_cls[1]  = b_cls;
    assign op_sign[0] = a_sign;
    assign op_sign[1] = b_sign;
    assign op_pay[0]  = a_pay;
    assign op_pay[1]  = b_pay;

    for (genvar g = 0; g < NOPS; g++) begin : g_rank
        fmr_rank u_rank (
            .cls_i  (op_cls[g]),
            .rank_o (op_rank[g]),
            .nan_o  (op_nan[g]),
            .snan_o (op_snan[g])
        );
    end

    logic  heavy_idx;
    rank_t heavy_rank, light_rank;

    fmr_sort u_sort (
        .rank_a_i     (op_rank[0]),
        .rank_b_i     (op_rank[1]),
        .heavy_idx_o  (heavy_idx),
        .heavy_rank_o (heavy_rank),
        .light_rank_o (light_rank)
    );

    logic sign_x;
    logic nan_pick;
    assign sign_x   = a_sign ^ b_sign;
    assign nan_pick = ~op_nan[0];

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.snan  = op_snan[0] | op_snan[1];
            if (op_nan[0] || op_nan[1]) begin
                res_d.bypass = 1'b1;
                res_d.pick   = nan_pick;
                res_d.cls    = op_cls[nan_pick];
                res_d.sign   = op_sign[nan_pick];
                res_d.pay    = op_pay[nan_pick];
            end else if (heavy_rank == RANK_INF) begin
                res_d.bypass = 1'b1;
                if (light_rank == RANK_ZERO) begin
                    res_d.cls  = CLS_QNAN;
                    res_d.dflt = 1'b1;
                    res_d.pay  = DFLT_PAY;
                    res_d.imz  = 1'b1;
                end else begin
                    res_d.cls  = CLS_INF;
                    res_d.sign = sign_x;
                    res_d.pick = heavy_idx;
                    res_d.pay  = op_pay[heavy_idx];
                end
            end else if (light_rank == RANK_ZERO) begin
                res_d.bypass = 1'b1;
                res_d.cls    = CLS_ZERO;
                res_d.sign   = sign_x;
                res_d.pick   = ~heavy_idx;
                res_d.pay    = op_pay[~heavy_idx];
            end else begin
                res_d.cls  = CLS_NUM;
                res_d.sign = sign_x;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid  = res_q.valid;
    assign out_bypass = res_q.bypass;
    assign out_cls    = res_q.cls;
    assign out_sign   = res_q.sign;
    assign out_pick   = res_q.pick;
    assign out_dflt   = res_q.dflt;
    assign out_pay    = res_q.pay;
    assign flag_snan  = res_q.snan;
    assign flag_imz   = res_q.imz;
endmodule

// File: rtl/fmul_special_resolver_chk.sv
module fmul_special_resolver_chk #(
    parameter int PAY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       a_cls,
    input logic [2:0]       b_cls,
    input logic             out_valid,
    input logic             out_bypass,
    input logic [2:0]       out_cls,
    input logic             out_sign,
    input logic             out_pick,
    input logic             out_dflt,
    input logic [PAY_W-1:0] out_pay,
    input logic             flag_snan,
    input logic             flag_imz
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_bypass && out_cls == 3'd0 && !out_sign
                       && !out_pick && !out_dflt && out_pay == '0
                       && !flag_snan && !flag_imz));
    // R2
    snan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_cls == 3'd4 || b_cls == 3'd4)) |=> flag_snan);
    // R1
    nan_a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_cls >= 3'd3) |=> (out_bypass && !out_pick && !flag_imz));
    // R3
    imz_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_imz |-> (out_bypass && out_cls == 3'd3 && !out_sign && out_dflt));
    // R9
    dflt_only_imz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dflt |-> flag_imz);
    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bypass) |-> (out_cls == 3'd1 && !flag_snan && !flag_imz
                                         && !out_dflt && !out_pick));
endmodule

bind fmul_special_resolver fmul_special_resolver_chk #(.PAY_W(PAY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .a_cls      (a_cls),
    .b_cls      (b_cls),
    .out_valid  (out_valid),
    .out_bypass (out_bypass),
    .out_cls    (out_cls),
    .out_sign   (out_sign),
    .out_pick   (out_pick),
    .out_dflt   (out_dflt),
    .out_pay    (out_pay),
    .flag_snan  (flag_snan),
    .flag_imz   (flag_imz)
);

// File: tb/fmul_special_resolver_tb.sv
`timescale 1ns/1ps
module fmul_special_resolver_tb;
    localparam int PAY_W = 8;
    localparam logic [PAY_W-1:0] DFLT = 8'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] a_cls = '0, b_cls = '0;
    logic a_sign = 1'b0, b_sign = 1'b0;
    logic [PAY_W-1:0] a_pay = '0, b_pay = '0;
    logic out_valid, out_bypass, out_sign, out_pick, out_dflt, flag_snan, flag_imz;
    logic [2:0] out_cls;
    logic [PAY_W-1:0] out_pay;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fmul_special_resolver #(.PAY_W(PAY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_cls(a_cls), .a_sign(a_sign), .a_pay(a_pay),
        .b_cls(b_cls), .b_sign(b_sign), .b_pay(b_pay),
        .out_valid(out_valid), .out_bypass(out_bypass), .out_cls(out_cls),
        .out_sign(out_sign), .out_pick(out_pick), .out_dflt(out_dflt),
        .out_pay(out_pay), .flag_snan(flag_snan), .flag_imz(flag_imz)
    );

    function automatic logic [18:0] pack_out(logic v, logic byp, logic [2:0] c, logic s,
                                             logic p, logic d, logic [7:0] py,
                                             logic fs, logic fi);
        return {v, byp, c, s, p, d, py, fs, fi, 1'b0};
    endfunction

    function automatic logic [18:0] actual();
        return pack_out(out_valid, out_bypass, out_cls, out_sign, out_pick,
                        out_dflt, out_pay, flag_snan, flag_imz);
    endfunction

    task automatic check(string req, logic [18:0] exp);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: a_cls=%0d b_cls=%0d actual=%h expected=%h",
                     req, a_cls, b_cls, actual(), exp);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [18:0] zero_out;
        zero_out = pack_out(0, 0, 3'd0, 0, 0, 0, 8'h00, 0, 0);
        repeat (3) @(negedge clk);
        check("R8 reset", zero_out);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after release", zero_out);

        for (int ac = 0; ac < 8; ac++) begin
            for (int bc = 0; bc < 8; bc++) begin
                for (int sg = 0; sg < 4; sg++) begin
                    logic an, bn, ai, bi, az, bz, sx, fs;
                    logic [18:0] exp;
                    string req;
                    a_cls = ac[2:0]; b_cls = bc[2:0];
                    a_sign = sg[0]; b_sign = sg[1];
                    a_pay = 8'h11 + 8'(ac * 8 + sg);
                    b_pay = 8'h51 + 8'(bc * 8 + sg);
                    in_valid = 1'b1;
                    an = (ac >= 3); bn = (bc >= 3);
                    ai = (ac == 2); bi = (bc == 2);
                    az = (ac == 0); bz = (bc == 0);
                    sx = a_sign ^ b_sign;
                    fs = (ac == 4) || (bc == 4);
                    if (an) begin
                        req = "R1 nan a"; exp = pack_out(1, 1, a_cls, a_sign, 0, 0, a_pay, fs, 0);
                    end else if (bn) begin
                        req = "R1 nan b"; exp = pack_out(1, 1, b_cls, b_sign, 1, 0, b_pay, fs, 0);
                    end else if ((ai && bz) || (bi && az)) begin
                        req = "R3 inf*zero"; exp = pack_out(1, 1, 3'd3, 0, 0, 1, DFLT, 0, 1);
                    end else if (bi) begin
                        req = "R4 inf b"; exp = pack_out(1, 1, 3'd2, sx, 1, 0, b_pay, 0, 0);
                    end else if (ai) begin
                        req = "R4 inf a"; exp = pack_out(1, 1, 3'd2, sx, 0, 0, a_pay, 0, 0);
                    end else if (az) begin
                        req = "R5 zero a"; exp = pack_out(1, 1, 3'd0, sx, 0, 0, a_pay, 0, 0);
                    end else if (bz) begin
                        req = "R5 zero b"; exp = pack_out(1, 1, 3'd0, sx, 1, 0, b_pay, 0, 0);
                    end else begin
                        req = "R6 numbers"; exp = pack_out(1, 0, 3'd1, sx, 0, 0, 8'h00, 0, 0);
                    end
                    @(negedge clk);
                    check(req, exp);
                    if (fs) check("R2 snan", exp);
                    if (exp[1]) check("R9 imz only here", exp);
                    if (sg == 3 && bc == 7) begin
                        in_valid = 1'b0;
                        @(negedge clk);
                        check("R7 idle clears", zero_out);
                    end
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 final idle", zero_out);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule